// File: doc/BRIEF.md
# Supply Supervisor with Automatic Restore for Nonvolatile SRAM

This block watches the supply of a nonvolatile SRAM through three digitised comparator flags. The first says the supply is below the brown-out level of 3.0 V. The second says it is above the recovery level of 4.25 V. The third says it is below the 4.0 V store-safe level. A restore request is armed at reset and re-armed whenever the supply sinks below the brown-out level. The request is acted on only once the supply climbs past the recovery level. At that point the block fires a one-cycle start strobe toward the nonvolatile-to-SRAM transfer engine. It then keeps the SRAM closed to ordinary reads and writes for a fixed restore window, which is nominally 550 microseconds.

The store-safe flag drives a store-inhibit output, independent of the restore machinery. When the restore window closes, the block samples a "write condition present" input. If a write is pending at that instant, the restored data is corrupted, so the block raises a sticky warning. The warning stays up until the next restore starts. A brown-out during a restore aborts the window, re-arms the request and keeps access closed.

Top module: `pwr_recall_supervisor`

## Requirements
- R1: While reset is asserted (rst_n=0), and on the first cycles after it, access_block=1, recall_start=0, wr_corrupt_warn=0 and store_inhibit=1. Reset leaves the request armed.
- R2: Each comparator flag passes through a two-flop synchroniser. A change on sup_above_hi or sup_below_lo shows at recall_start or access_block on the third rising edge after it, and not earlier. A change on sup_below_mid shows at store_inhibit on the second edge.
- R3: With the request armed, sup_above_hi=1 together with sup_below_lo=0 produces recall_start=1 for exactly one cycle and disarms the request.
- R4: access_block stays 1 for exactly RESTORE_CYCLES = CLK_MHZ*RESTORE_US cycles, counted from the cycle in which recall_start is 1. It falls to 0 in the following cycle.
- R5: In the ready state (access_block=0), sup_below_lo=1 re-arms the request and sets access_block=1. A later rise above the recovery level starts a new restore.
- R6: sup_below_lo=1 during a restore aborts it. access_block stays 1 past the original window end, and no access opens until a fresh recall_start has been followed by a full window.
- R7: store_inhibit equals the synchronised sup_below_mid in every state, and no other input affects it.
- R8: At the cycle a restore window ends, wr_corrupt_warn takes the value of wr_state sampled at that edge. It holds that value until the next recall_start, and it is cleared in the same cycle as that strobe.
- R9: Once the request is disarmed, sup_above_hi staying high or toggling produces no further recall_start, and access_block stays 0 in the ready state.
- R10: While armed, sup_above_hi=1 with sup_below_lo=1 (inconsistent comparator flags) does not start a restore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sup_below_lo | input | 1 | Comparator flag: supply below 3.0 V (asynchronous) |
| sup_above_hi | input | 1 | Comparator flag: supply above 4.25 V (asynchronous) |
| sup_below_mid | input | 1 | Comparator flag: supply below 4.0 V (asynchronous) |
| wr_state | input | 1 | SRAM write condition present on the memory pins (synchronous) |
| recall_start | output | 1 | One-cycle strobe launching the automatic restore |
| access_block | output | 1 | SRAM reads and writes must be refused while 1 |
| store_inhibit | output | 1 | Stores must be refused while 1 |
| wr_corrupt_warn | output | 1 | Sticky: a write condition was present when the last restore ended |

## Verification
Suppose the controller took a wrong state, for example dropping the armed request or leaving a restore early. The fault would show at the ports no later than the next window boundary. access_block would fall before or after the exact cycle that R4 fixes, or a recall_start would be missing three edges after the recovery flag rises. A wrong restore counter shows as the window edge moving by a cycle. The bench therefore samples access_block on both sides of that edge. The abort path is observed by holding past the original window end and checking that access stays closed.

// File: rtl/pfm_pkg.sv
package pfm_pkg;
  typedef enum logic [1:0] {
    ST_ARMED   = 2'd0,
    ST_RESTORE = 2'd1,
    ST_READY   = 2'd2
  } pfm_state_e;

  function automatic int unsigned restore_cycles(input int unsigned clk_mhz,
                                                 input int unsigned window_us);
    return clk_mhz * window_us;
  endfunction
endpackage

// File: rtl/pfm_sync.sv
module pfm_sync #(
  parameter int unsigned W       = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic [W-1:0] stg_in;
    if (i == 0) begin : g_first
      assign stg_in = d;
    end else begin : g_rest
      assign stg_in = stg[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= RST_VAL;
      else        stg[i] <= stg_in;
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pfm_restore_timer.sv
module pfm_restore_timer #(
  parameter int unsigned CYCLES = 137500,
  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic abort,
  output logic done
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (abort) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (load) begin
      cnt_en = 1'b1;
      cnt_d  = CW'(CYCLES - 1);
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/pfm_recall_fsm.sv
module pfm_recall_fsm
  import pfm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lo,
  input  logic       hi,
  input  logic       wr_state,
  input  logic       tmr_done,
  output logic       tmr_load,
  output logic       tmr_abort,
  output pfm_state_e state,
  output logic       start_q,
  output logic       warn_q
);
  pfm_state_e state_d;
  logic       launch, finish;
  logic       warn_en, warn_d;

  always_comb begin
    state_d = state;
    launch  = 1'b0;
    finish  = 1'b0;
    tmr_abort = 1'b0;
    unique case (state)
      ST_ARMED: begin
        if (hi && !lo) begin
          state_d = ST_RESTORE;
          launch  = 1'b1;
        end
      end
      ST_RESTORE: begin
        if (lo) begin
          state_d   = ST_ARMED;
          tmr_abort = 1'b1;
        end else if (tmr_done) begin
          state_d = ST_READY;
          finish  = 1'b1;
        end
      end
      ST_READY: begin
        if (lo) state_d = ST_ARMED;
      end
      default: state_d = ST_ARMED;
    endcase
  end

  assign tmr_load = launch;
  assign warn_en  = launch | finish;
  assign warn_d   = finish & wr_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_ARMED;
      start_q <= 1'b0;
    end else begin
      state   <= state_d;
      start_q <= launch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       warn_q <= 1'b0;
    else if (warn_en) warn_q <= warn_d;
  end

  // R3: the start strobe never lasts two cycles
  a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);

  // R8: the warning can only rise as a restore hands over to ready
  a_r8_warn_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warn_q) |-> (state == ST_READY && $past(state) == ST_RESTORE));

  // R9: a strobe only comes out of the armed state
  a_r9_start_from_armed: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> ($past(state) == ST_ARMED && state == ST_RESTORE));
endmodule

// File: rtl/pwr_recall_supervisor.sv
module pwr_recall_supervisor
  import pfm_pkg::*;
#(
  parameter int unsigned CLK_MHZ     = 250,
  parameter int unsigned RESTORE_US  = 550,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_below_lo,
  input  logic sup_above_hi,
  input  logic sup_below_mid,
  input  logic wr_state,
  output logic recall_start,
  output logic access_block,
  output logic store_inhibit,
  output logic wr_corrupt_warn
);
  localparam int unsigned RESTORE_CYCLES = restore_cycles(CLK_MHZ, RESTORE_US);
  localparam int unsigned NFLAG = 3;
  localparam logic [NFLAG-1:0] FLAG_RST = 3'b101; // {mid, hi, lo}: supply assumed low

  logic             rst_meta, rst_int_n;
  logic [NFLAG-1:0] flags_raw, flags_s;
  logic             lo_s, hi_s, mid_s;
  logic             tmr_load, tmr_abort, tmr_done;
  pfm_state_e       state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta  <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_meta  <= 1'b1;
      rst_int_n <= rst_meta;
    end
  end

  assign flags_raw = {sup_below_mid, sup_above_hi, sup_below_lo};

  pfm_sync #(.W(NFLAG), .STAGES(SYNC_STAGES), .RST_VAL(FLAG_RST)) u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .d    (flags_raw),
    .q    (flags_s)
  );

  assign lo_s  = flags_s[0];
  assign hi_s  = flags_s[1];
  assign mid_s = flags_s[2];

  pfm_restore_timer #(.CYCLES(RESTORE_CYCLES)) u_timer (
    .clk  (clk),
    .rst_n(rst_int_n),
    .load (tmr_load),
    .abort(tmr_abort),
    .done (tmr_done)
  );

  pfm_recall_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .lo       (lo_s),
    .hi       (hi_s),
    .wr_state (wr_state),
    .tmr_done (tmr_done),
    .tmr_load (tmr_load),
    .tmr_abort(tmr_abort),
    .state    (state),
    .start_q  (recall_start),
    .warn_q   (wr_corrupt_warn)
  );

  assign access_block  = (state != ST_READY);
  assign store_inhibit = mid_s;

  // R4: access opens only once the restore counter has run out
  a_r4_open_after_timer: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(access_block) |-> $past(tmr_done));

  // R3: a restore strobe always comes with access closed
  a_r3_start_blocks: assert property (@(posedge clk) disable iff (!rst_int_n)
    recall_start |-> access_block);

  // R5 / R6: a synchronised brown-out closes access on the next edge
  a_r6_low_blocks: assert property (@(posedge clk) disable iff (!rst_int_n)
    lo_s |=> access_block);

  // R10: no strobe while the brown-out flag was set
  a_r10_no_start_low: assert property (@(posedge clk) disable iff (!rst_int_n)
    recall_start |-> !$past(lo_s));
endmodule

// File: tb/pwr_recall_supervisor_bench.sv
module pwr_recall_supervisor_bench;
  localparam int unsigned CLK_MHZ = 1;
  localparam int unsigned WIN_US  = 16;
  localparam int RC = CLK_MHZ * WIN_US;

  logic clk = 1'b0;
  logic rst_n, lo, hi, mid, wr;
  logic recall_start, access_block, store_inhibit, warn;
  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  pwr_recall_supervisor #(.CLK_MHZ(CLK_MHZ), .RESTORE_US(WIN_US)) u_pwr_recall_supervisor (
    .clk(clk), .rst_n(rst_n), .sup_below_lo(lo), .sup_above_hi(hi),
    .sup_below_mid(mid), .wr_state(wr), .recall_start(recall_start),
    .access_block(access_block), .store_inhibit(store_inhibit),
    .wr_corrupt_warn(warn)
  );

  // table rows: {hi, mid, wr, expected store_inhibit}
  localparam logic [3:0] VEC [6] = '{4'b1000, 4'b1101, 4'b0101, 4'b0010, 4'b1111, 4'b0000};

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic l, input logic h, input logic m, input logic w);
    lo = l; hi = h; mid = m; wr = w;
  endtask

  // rises hi at a negedge; returns once recall_start is expected high
  task automatic launch(input string tag);
    hi = 1'b1; lo = 1'b0;
    tick(2);
    chk({tag, " R2 no strobe before 3rd edge"}, recall_start, 1'b0);
    tick(1);
    chk({tag, " R3 strobe"}, recall_start, 1'b1);
    chk({tag, " R4 blocked at start"}, access_block, 1'b1);
  endtask

  initial begin
    int bad;
    rst_n = 1'b0;
    drive(1'b1, 1'b0, 1'b1, 1'b0);
    tick(3);
    chk("R1 block in reset", access_block, 1'b1);
    chk("R1 no strobe in reset", recall_start, 1'b0);
    chk("R1 inhibit in reset", store_inhibit, 1'b1);
    chk("R1 no warn in reset", warn, 1'b0);
    rst_n = 1'b1;
    tick(4);
    chk("R1 armed after reset", access_block, 1'b1);

    // supply rises past brown-out and store-safe but not recovery
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    tick(2);
    chk("R2 inhibit follows mid at 2nd edge", store_inhibit, 1'b0);
    tick(4);
    chk("R3 no start without hi", recall_start, 1'b0);
    chk("R3 still blocked", access_block, 1'b1);

    launch("first");
    tick(1);
    chk("R3 strobe one cycle", recall_start, 1'b0);
    bad = 0;
    for (int k = 2; k < RC; k++) begin
      if (k == RC - 2) wr = 1'b1;
      tick(1);
      if (access_block !== 1'b1 || recall_start !== 1'b0) bad++;
    end
    chk("R4 blocked through window", (bad == 0), 1'b1);
    chk("R4 blocked on last window cycle", access_block, 1'b1);
    tick(1);
    chk("R4 opens after window", access_block, 1'b0);
    chk("R8 warn on write at end", warn, 1'b1);
    wr = 1'b0;

    // table walk in ready state
    for (int i = 0; i < 6; i++) begin
      hi = VEC[i][3]; mid = VEC[i][2]; wr = VEC[i][1];
      tick(3);
      chk("R7 inhibit table", store_inhibit, VEC[i][0]);
      chk("R9 ready untouched", access_block, 1'b0);
      chk("R9 no extra strobe", recall_start, 1'b0);
      chk("R8 warn held", warn, 1'b1);
    end

    // brown-out in ready
    drive(1'b1, 1'b0, 1'b1, 1'b0);
    tick(2);
    chk("R5 not before 3rd edge", access_block, 1'b0);
    tick(1);
    chk("R5 re-blocked", access_block, 1'b1);
    chk("R8 warn held until strobe", warn, 1'b1);
    tick(3);
    mid = 1'b0;
    launch("second");
    chk("R8 warn cleared with strobe", warn, 1'b0);

    // brown-out during restore
    tick(4);
    drive(1'b1, 1'b0, 1'b1, 1'b0);
    bad = 0;
    for (int k = 0; k < RC + 6; k++) begin
      tick(1);
      if (access_block !== 1'b1 || recall_start !== 1'b0) bad++;
    end
    chk("R6 aborted restore stays blocked", (bad == 0), 1'b1);

    // inconsistent flags while armed
    hi = 1'b1;
    tick(6);
    chk("R10 no start with lo and hi", recall_start, 1'b0);
    chk("R10 still blocked", access_block, 1'b1);
    lo = 1'b0; hi = 1'b0; mid = 1'b0;
    tick(4);
    launch("third");
    tick(RC - 1);
    chk("R6 blocked until full new window", access_block, 1'b1);
    tick(1);
    chk("R6 opens after fresh window", access_block, 1'b0);
    chk("R8 no warn without write", warn, 1'b0);

    // reset while ready
    rst_n = 1'b0;
    tick(1);
    chk("R1 block on mid-run reset", access_block, 1'b1);
    chk("R1 inhibit on mid-run reset", store_inhibit, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule